// File: doc/BRIEF.md
# SMII receive segment serializer

This block sits on the PHY side of a serial media-independent receive path. Every ten reference clocks it sends one ten-bit segment on a single serial line and marks the segment's first bit with a one-clock sync pulse. The first bit of a segment is carrier sense. The second is the data-valid flag. The last eight carry either a received byte or, while no frame is active, a status byte that describes the line.

The parallel inputs are registered once per segment, on the clock edge that opens the segment. In 100 Mbps mode every segment carries fresh content. In 10 Mbps mode one captured segment is sent ten times in a row. In both modes the carrier-sense bit is sampled again for every segment. In 100 Mbps mode, a nibble that came from an invalid line symbol is replaced by a fixed error pattern.

The control is a small state machine over the slots of a segment. IDLE is the reset state. The first clock after reset moves it to CRS (slot 0). CRS always moves to DV (slot 1). DV always moves to DATA (slots 2 to 9). DATA loops on itself for data bits 0 to 6, and after bit 7 it returns to CRS, which opens the next segment. A repeat counter, which is active only in 10 Mbps mode, decides at each entry into CRS whether a new segment is captured.

Top module: `smii_rx_serializer`

## Requirements
- R1: While `rst_n` is low, `smii_sync` and `smii_rxd` are 0. The first rising clock edge after reset is released opens a segment, so `smii_sync` is high for the cycle that follows that edge.
- R2: `smii_sync` is high for exactly one clock out of every ten, and always in the cycle that carries slot 0.
- R3: Slot 0 carries carrier sense and slot 1 carries data valid. Slots 2 to 9 carry payload bits 0 to 7, least significant bit first.
- R4: `rx_valid`, `rx_byte`, `sym_err_lo`, `sym_err_hi` and `line_status` are sampled only at the edge that opens a segment. A change to any of them later in the same segment has no effect on that segment's bits.
- R5: In 100 Mbps mode (`mode_10m` = 0), every segment carries the inputs that were sampled at its own opening edge.
- R6: In 10 Mbps mode (`mode_10m` = 1), a segment is captured, sent, and then repeated unchanged in slots 1 to 9 for nine more segments. The next capture happens on the eleventh segment. A capture happens on the first segment boundary after 10 Mbps mode is entered from 100 Mbps mode.
- R7: Slot 0 of every segment, in both modes, equals `rx_carrier` as sampled at that segment's opening edge.
- R8: When data valid is 0, the payload is the status byte: bit 0 receive error, bit 1 speed, bit 2 duplex, bit 3 link, bit 4 jabber, bit 5 upper nibble of the last byte of the previous frame valid, bit 6 false carrier, bit 7 always 0. These are taken from `line_status[6:0]` bit for bit.
- R9: In 100 Mbps mode with data valid set, `sym_err_lo` replaces payload bits 3:0 with 4'b0101 and `sym_err_hi` replaces bits 7:4 with 4'b0101. Neither flag has any effect in 10 Mbps mode or while data valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_10m | input | 1 | 1 selects 10 Mbps repetition, 0 selects 100 Mbps |
| rx_carrier | input | 1 | Live receive carrier sense |
| rx_valid | input | 1 | Receive data valid |
| rx_byte | input | 8 | Received data byte |
| sym_err_lo | input | 1 | Lower nibble came from an invalid symbol |
| sym_err_hi | input | 1 | Upper nibble came from an invalid symbol |
| line_status | input | 7 | Status fields sent while no frame is active (bit map in R8) |
| smii_rxd | output | 1 | Serial receive line |
| smii_sync | output | 1 | One-clock pulse marking slot 0 |

## Verification
At a segment boundary inside a 10 Mbps repeat window, two things happen on the same edge. Carrier sense is sampled live, while the capture of new slot 1 to 9 content is suppressed. The bench changes `rx_carrier` together with the byte, the valid flag and the status inputs on boundaries inside a window. It then checks that slot 0 follows the new carrier value while the other nine slots still show the window's first capture. A second collision of this kind comes from input changes in the middle of a segment. These fall in the same cycles as the serializer shifting out bits taken from the captured register. The bench flips every parallel input at slot 4 and expects no change in the bits that follow.

// File: rtl/smii_rx_pkg.sv
package smii_rx_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_CRS  = 2'd1,
        S_DV   = 2'd2,
        S_DATA = 2'd3
    } slot_state_e;

    localparam int          NIBBLE_W   = 4;
    localparam logic [3:0]  ERR_NIBBLE = 4'b0101;

endpackage

// File: rtl/smii_slot_sched.sv
module smii_slot_sched
    import smii_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int REPEAT = 10
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        mode_10m,
    output slot_state_e                 state_q,
    output slot_state_e                 state_n,
    output logic [$clog2(DATA_W)-1:0]   idx_n,
    output logic                        seg_start,
    output logic                        capture_en
);

    localparam int IDX_W = $clog2(DATA_W);
    localparam int REP_W = $clog2(REPEAT);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);
    localparam logic [REP_W-1:0] REP_LAST = REP_W'(REPEAT - 1);

    logic [IDX_W-1:0] idx_q;
    logic [REP_W-1:0] rep_q;
    logic [REP_W-1:0] rep_n;

    // next-state logic over the slots of a segment
    always_comb begin
        state_n = state_q;
        idx_n   = idx_q;
        unique case (state_q)
            S_IDLE: begin
                state_n = S_CRS;
            end
            S_CRS: begin
                state_n = S_DV;
            end
            S_DV: begin
                state_n = S_DATA;
                idx_n   = '0;
            end
            S_DATA: begin
                if (idx_q == IDX_LAST) begin
                    state_n = S_CRS;
                    idx_n   = '0;
                end else begin
                    idx_n = idx_q + 1'b1;
                end
            end
            default: begin
                state_n = S_IDLE;
            end
        endcase
    end

    assign seg_start  = (state_n == S_CRS);
    assign capture_en = seg_start && (!mode_10m || rep_q == '0);

    always_comb begin
        rep_n = rep_q;
        if (seg_start) begin
            if (!mode_10m)
                rep_n = '0;
            else if (rep_q == REP_LAST)
                rep_n = '0;
            else
                rep_n = rep_q + 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
            rep_q   <= '0;
        end else begin
            state_q <= state_n;
            idx_q   <= idx_n;
            rep_q   <= rep_n;
        end
    end

    // R2: slot 0 is always followed by slot 1
    a_r2_crs_then_dv: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CRS) |=> (state_q == S_DV));

    // R2: a segment never closes before its last data bit
    a_r2_data_len: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DATA && state_n == S_CRS) |-> (idx_q == IDX_LAST));

    // R6: repeat counter stays in range
    a_r6_rep_range: assert property (@(posedge clk) disable iff (!rst_n)
        rep_q <= REP_LAST);

endmodule

// File: rtl/smii_seg_builder.sv
module smii_seg_builder
    import smii_rx_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int STATUS_W = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  capture_en,
    input  logic                  mode_10m,
    input  logic                  rx_valid,
    input  logic [DATA_W-1:0]     rx_byte,
    input  logic                  sym_err_lo,
    input  logic                  sym_err_hi,
    input  logic [STATUS_W-1:0]   line_status,
    output logic [DATA_W:0]       payload_q
);

    localparam int PAY_W = DATA_W + 1;

    logic [DATA_W-1:0] data_sub;
    logic [DATA_W-1:0] status_byte;
    logic [PAY_W-1:0]  payload_n;

    always_comb begin
        data_sub = rx_byte;
        if (!mode_10m) begin
            if (sym_err_lo)
                data_sub[NIBBLE_W-1:0] = ERR_NIBBLE;
            if (sym_err_hi)
                data_sub[DATA_W-1:NIBBLE_W] = ERR_NIBBLE;
        end
    end

    assign status_byte = {{(DATA_W - STATUS_W){1'b0}}, line_status};
    assign payload_n   = rx_valid ? {data_sub, 1'b1} : {status_byte, 1'b0};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            payload_q <= '0;
        else if (capture_en)
            payload_q <= payload_n;
    end

    // R4 / R6: no capture means the segment content holds
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_en |=> $stable(payload_q));

    // R9: lower-nibble error pattern at 100 Mbps
    a_r9_err_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_en && !mode_10m && rx_valid && sym_err_lo)
            |=> (payload_q[NIBBLE_W:1] == ERR_NIBBLE));

    // R8: status byte carries a clear valid flag and a zero top bit
    a_r8_status: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_en && !rx_valid) |=> (!payload_q[0] && !payload_q[DATA_W]));

endmodule

// File: rtl/smii_rx_serializer.sv
module smii_rx_serializer
    import smii_rx_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int STATUS_W = 7,
    parameter int REPEAT   = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_10m,
    input  logic                rx_carrier,
    input  logic                rx_valid,
    input  logic [DATA_W-1:0]   rx_byte,
    input  logic                sym_err_lo,
    input  logic                sym_err_hi,
    input  logic [STATUS_W-1:0] line_status,
    output logic                smii_rxd,
    output logic                smii_sync
);

    localparam int IDX_W = $clog2(DATA_W);
    localparam int SEL_W = $clog2(DATA_W + 1);

    slot_state_e        state_q;
    slot_state_e        state_n;
    logic [IDX_W-1:0]   idx_n;
    logic               seg_start;
    logic               capture_en;
    logic [DATA_W:0]    payload_q;
    logic [SEL_W-1:0]   bit_sel;
    logic               line_q;
    logic               sync_q;

    smii_slot_sched #(
        .DATA_W (DATA_W),
        .REPEAT (REPEAT)
    ) u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_10m   (mode_10m),
        .state_q    (state_q),
        .state_n    (state_n),
        .idx_n      (idx_n),
        .seg_start  (seg_start),
        .capture_en (capture_en)
    );

    smii_seg_builder #(
        .DATA_W   (DATA_W),
        .STATUS_W (STATUS_W)
    ) u_build (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture_en  (capture_en),
        .mode_10m    (mode_10m),
        .rx_valid    (rx_valid),
        .rx_byte     (rx_byte),
        .sym_err_lo  (sym_err_lo),
        .sym_err_hi  (sym_err_hi),
        .line_status (line_status),
        .payload_q   (payload_q)
    );

    assign bit_sel = SEL_W'(idx_n) + 1'b1;

    // output process: the bit for the slot being entered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            sync_q <= seg_start;
            unique case (state_n)
                S_CRS:   line_q <= rx_carrier;
                S_DV:    line_q <= payload_q[0];
                S_DATA:  line_q <= payload_q[bit_sel];
                default: line_q <= 1'b0;
            endcase
        end
    end

    assign smii_rxd  = line_q;
    assign smii_sync = sync_q;

    // R1: quiet outputs during reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (!sync_q && !line_q));

    // R2: sync marks slot 0 only
    a_r2_sync_slot0: assert property (@(posedge clk) disable iff (!rst_n)
        sync_q |-> (state_q == S_CRS));

    // R7: slot 0 is the carrier sampled at the opening edge
    a_r7_live_crs: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_q && state_q == S_CRS && $past(rst_n)) |-> (line_q == $past(rx_carrier)));

    // R3: slot 1 shows the captured valid flag
    a_r3_dv_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DV) |-> (line_q == payload_q[0]));

endmodule

// File: tb/sim_smii_rx_serializer.sv
`timescale 1ns/1ps
module sim_smii_rx_serializer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_10m = 1'b0;
    logic       rx_carrier = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       sym_err_lo = 1'b0;
    logic       sym_err_hi = 1'b0;
    logic [6:0] line_status = 7'h00;
    logic       smii_rxd;
    logic       smii_sync;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    smii_rx_serializer u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_10m    (mode_10m),
        .rx_carrier  (rx_carrier),
        .rx_valid    (rx_valid),
        .rx_byte     (rx_byte),
        .sym_err_lo  (sym_err_lo),
        .sym_err_hi  (sym_err_hi),
        .line_status (line_status),
        .smii_rxd    (smii_rxd),
        .smii_sync   (smii_sync)
    );

    task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_payload(input logic m10, input logic dv,
            input logic [7:0] b, input logic el, input logic eh, input logic [6:0] st);
        logic [7:0] d;
        if (dv) begin
            d = b;
            if (!m10 && el) d[3:0] = 4'b0101;
            if (!m10 && eh) d[7:4] = 4'b0101;
        end else begin
            d = {1'b0, st};
        end
        return d;
    endfunction

    // drives inputs before a boundary, then checks one full segment;
    // every parallel input is flipped at slot 4 (R4)
    task automatic run_seg(input string tag, input logic crs, input logic dv,
            input logic [7:0] b, input logic el, input logic eh, input logic [6:0] st,
            input logic exp_dv, input logic [7:0] exp_d);
        logic [9:0] bits;
        logic [9:0] syncs;
        rx_carrier  = crs;
        rx_valid    = dv;
        rx_byte     = b;
        sym_err_lo  = el;
        sym_err_hi  = eh;
        line_status = st;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            bits[i]  = smii_rxd;
            syncs[i] = smii_sync;
            if (i == 4) begin
                rx_valid    = ~dv;
                rx_byte     = ~b;
                sym_err_lo  = ~el;
                sym_err_hi  = ~eh;
                line_status = ~st;
            end
        end
        chk({"R2 sync pattern ", tag}, syncs, 10'h001);
        chk({"R7 slot0 carrier ", tag}, {9'd0, bits[0]}, {9'd0, crs});
        chk({"R3 slot1 valid ", tag}, {9'd0, bits[1]}, {9'd0, exp_dv});
        chk({"R3 R4 payload ", tag}, {2'd0, bits[9:2]}, {2'd0, exp_d});
    endtask

    task automatic t_reset;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R1 reset outputs", {8'd0, smii_sync, smii_rxd}, 10'd0);
        end
        rst_n = 1'b1;
    endtask

    task automatic t_fast_data;
        logic [7:0] pat [4] = '{8'hA5, 8'h3C, 8'h01, 8'h80};
        for (int k = 0; k < 4; k++)
            run_seg("R5 data", k[0], 1'b1, pat[k], 1'b0, 1'b0, 7'h55,
                    1'b1, exp_payload(1'b0, 1'b1, pat[k], 1'b0, 1'b0, 7'h55));
    endtask

    task automatic t_status;
        logic [6:0] st [3] = '{7'h01, 7'h2A, 7'h7F};
        for (int k = 0; k < 3; k++)
            run_seg("R8 status", 1'b1, 1'b0, 8'hFF, 1'b1, 1'b1, st[k],
                    1'b0, exp_payload(1'b0, 1'b0, 8'hFF, 1'b1, 1'b1, st[k]));
    endtask

    task automatic t_err;
        run_seg("R9 err lo", 1'b1, 1'b1, 8'hFF, 1'b1, 1'b0, 7'h00, 1'b1, 8'hF5);
        run_seg("R9 err hi", 1'b1, 1'b1, 8'h00, 1'b0, 1'b1, 7'h00, 1'b1, 8'h50);
        run_seg("R9 err both", 1'b0, 1'b1, 8'hCC, 1'b1, 1'b1, 7'h00, 1'b1, 8'h55);
    endtask

    task automatic t_slow;
        mode_10m = 1'b1;
        // window opens with errors flagged: no substitution at 10 Mbps
        run_seg("R6 R9 slow first", 1'b0, 1'b1, 8'h9E, 1'b1, 1'b1, 7'h00, 1'b1, 8'h9E);
        for (int k = 1; k < 10; k++)
            run_seg("R6 R7 slow repeat", k[0], 1'b0, 8'h11, 1'b0, 1'b0, 7'h3F, 1'b1, 8'h9E);
        run_seg("R6 slow next window", 1'b1, 1'b0, 8'h11, 1'b0, 1'b0, 7'h3F, 1'b0, 8'h3F);
        for (int k = 1; k < 10; k++)
            run_seg("R6 slow hold", ~k[0], 1'b1, 8'h77, 1'b0, 1'b0, 7'h00, 1'b0, 8'h3F);
        mode_10m = 1'b0;
        run_seg("R5 back to fast", 1'b1, 1'b1, 8'h6B, 1'b0, 1'b0, 7'h00, 1'b1, 8'h6B);
    endtask

    initial begin
        t_reset;
        t_fast_data;
        t_status;
        t_err;
        t_slow;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule